// File: doc/BRIEF.md
# Four-State Snooping Cache Controller

This block is one private cache controller for a small shared-bus multiprocessor. It holds a direct-mapped, write-back array where every line carries a coherence state, a tag and a single data word. Processor reads and writes that can finish locally do so without touching the bus. Everything else becomes a bus transaction: a shared read, a read-for-ownership, or a write-back of a dirty victim. At the same time the controller watches the transactions that other caches put on the bus and reacts to them.

Lines are Modified, Exclusive, Shared or Invalid. A read miss samples a wired-OR "copy exists" line that every other holder drives, and fills as Shared or Exclusive according to it. A dirty holder answers a snooped read or read-for-ownership by supplying its word, and the bus uses that word in place of the memory value. Arbitration, the memory and the wired-OR combine sit outside the block. The bus carries one transaction per granted cycle, and snoop responses are combinational in that same cycle.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `cpu_done` are low, and the first access to any address misses.
- R2: A read miss requests the bus with command 0 (shared read) and fills the line as Shared when `bus_shared` is high in the grant cycle, and as Exclusive when it is low.
- R3: While snooping a command-0 read whose address it holds in Shared, Exclusive or Modified, the controller drives `snp_shared` high in that cycle.
- R4: A processor write that hits an Exclusive line completes with no bus request and leaves the line Modified.
- R5: A processor write that hits a Shared line or misses requests the bus with command 1 (read-for-ownership) and leaves the line Modified; the upgrade from Shared is never silent.
- R6: A snooped command-0 read that hits a Modified line raises `snp_flush` with the word on `snp_data` and moves the line to Shared; the requester fills with that word, not the memory value.
- R7: A snooped command-1 transaction that hits a line moves it to Invalid, and a Modified holder also flushes its word.
- R8: A snooped command-0 read that hits an Exclusive line moves it to Shared without flushing; only a Modified holder supplies data.
- R9: A miss whose victim is Modified first writes the victim back with command 2 at the victim's address, then issues the fill; a Shared or Exclusive victim is dropped with no bus traffic.
- R10: Processor reads that hit in any valid state, and writes that hit in Modified, complete with no bus request.
- R11: A snoop that hits the line a pending processor request uses wins: the request drops `bus_req`, and it is re-evaluated against the new state of the line.
- R12: `cpu_done` is a one-cycle pulse; while `bus_req` waits for `bus_gnt` with no conflicting snoop, `bus_cmd` and `bus_addr` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held with its fields until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; the low bits select the line |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 2 | 0 shared read, 1 read-for-ownership, 2 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_gnt | input | 1 | Transaction carried in this cycle |
| bus_shared | input | 1 | Wired-OR of the other caches' `snp_shared` |
| bus_rdata | input | DATA_W | Fill word (flushed word or memory) |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped read's address |
| snp_flush | output | 1 | This cache supplies the snooped word |
| snp_data | output | DATA_W | Supplied word |

## Verification
The assertions assume that a processor request keeps its write flag, address and data unchanged from assertion until `cpu_done`, and that `bus_gnt` and `snp_valid` never reach the same controller in one cycle. The bench drives each request at a falling edge and holds it until the completion pulse has been seen. Its bus model grants one requester per cycle with fixed priority and presents that transaction as a snoop only to the other cache. Simultaneous writes to a line both caches share exercise the abandon-and-retry path without breaking either assumption.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2,
        LN_MOD = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_READ  = 2'd0,
        BC_READX = 2'd1,
        BC_FLUSH = 2'd2
    } bus_cmd_e;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_WB   = 2'd1,
        F_FILL = 2'd2,
        F_RESP = 2'd3
    } fsm_e;

    typedef struct packed {
        logic hit;
        logic shared;
        logic flush;
        logic upd;
    } snoop_rsp_t;

    // State a snooped transaction leaves behind in a line it hits
    function automatic line_st_e snoop_next(input line_st_e cur, input logic [1:0] cmd);
        line_st_e r;
        r = cur;
        if (cmd == BC_READ && cur != LN_INV)
            r = LN_SHR;
        else if (cmd == BC_READX)
            r = LN_INV;
        return r;
    endfunction

    function automatic line_st_e fill_state(input logic shared_seen);
        return shared_seen ? LN_SHR : LN_EXC;
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    // processor-side port
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic              a_wen,
    input  line_st_e          a_wst,
    input  logic [TAG_W-1:0]  a_wtag,
    input  logic [DATA_W-1:0] a_wdata,
    // snoop-side port (state only on write)
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              b_wen,
    input  line_st_e          b_wst
);

    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i]   <= LN_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (b_wen && b_idx == IDX_W'(i)) begin
                st_q[i] <= b_wst;
            end else if (a_wen && a_idx == IDX_W'(i)) begin
                st_q[i]   <= a_wst;
                tag_q[i]  <= a_wtag;
                data_q[i] <= a_wdata;
            end
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_e         ln_st,
    input  logic [TAG_W-1:0] ln_tag,
    output snoop_rsp_t       rsp,
    output line_st_e         upd_st
);

    logic acts;

    always_comb begin
        acts       = (snp_cmd == BC_READ) || (snp_cmd == BC_READX);
        rsp.hit    = snp_valid && acts && (ln_st != LN_INV) && (ln_tag == snp_tag);
        rsp.shared = rsp.hit && (snp_cmd == BC_READ);
        rsp.flush  = rsp.hit && (ln_st == LN_MOD);
        rsp.upd    = rsp.hit;
        upd_st     = snoop_next(ln_st, snp_cmd);
    end

endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  line_st_e          ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    input  logic              snp_conflict,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_shared,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              wr_en,
    output line_st_e          wr_st,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data
);

    fsm_e              cur_q, nxt;
    bus_cmd_e          cmd_q, cmd_n;
    logic [DATA_W-1:0] rdata_q, rdata_n;
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic              hit;

    assign req_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign req_idx = cpu_addr[IDX_W-1:0];
    assign hit     = (ln_st != LN_INV) && (ln_tag == req_tag);

    always_comb begin
        nxt     = cur_q;
        cmd_n   = cmd_q;
        rdata_n = rdata_q;
        wr_en   = 1'b0;
        wr_st   = ln_st;
        wr_tag  = req_tag;
        wr_data = cpu_wdata;
        case (cur_q)
            F_IDLE: begin
                if (cpu_req && !snp_conflict) begin
                    if (hit && !cpu_we) begin
                        rdata_n = ln_data;
                        nxt     = F_RESP;
                    end else if (hit && (ln_st == LN_MOD || ln_st == LN_EXC)) begin
                        wr_en = 1'b1;
                        wr_st = LN_MOD;
                        nxt   = F_RESP;
                    end else if (!hit && ln_st == LN_MOD) begin
                        cmd_n = BC_FLUSH;
                        nxt   = F_WB;
                    end else begin
                        cmd_n = cpu_we ? BC_READX : BC_READ;
                        nxt   = F_FILL;
                    end
                end
            end
            F_WB: begin
                if (snp_conflict) begin
                    nxt = F_IDLE;
                end else if (bus_gnt) begin
                    wr_en   = 1'b1;
                    wr_st   = LN_INV;
                    wr_tag  = ln_tag;
                    wr_data = ln_data;
                    nxt     = F_IDLE;
                end
            end
            F_FILL: begin
                if (snp_conflict) begin
                    nxt = F_IDLE;
                end else if (bus_gnt) begin
                    wr_en = 1'b1;
                    if (cpu_we) begin
                        wr_st = LN_MOD;
                    end else begin
                        wr_st   = fill_state(bus_shared);
                        wr_data = bus_rdata;
                        rdata_n = bus_rdata;
                    end
                    nxt = F_RESP;
                end
            end
            default: nxt = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= F_IDLE;
            cmd_q   <= BC_READ;
            rdata_q <= '0;
        end else begin
            cur_q   <= nxt;
            cmd_q   <= cmd_n;
            rdata_q <= rdata_n;
        end
    end

    assign cpu_done  = (cur_q == F_RESP);
    assign cpu_rdata = rdata_q;
    assign bus_req   = (cur_q == F_WB) || (cur_q == F_FILL);
    assign bus_cmd   = cmd_q;
    assign bus_addr  = (cur_q == F_WB) ? {ln_tag, req_idx} : cpu_addr;
    assign bus_wdata = ln_data;

    // R2
    fill_state_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == F_FILL && bus_gnt && !snp_conflict && !cpu_we)
        |=> (ln_st == ($past(bus_shared) ? LN_SHR : LN_EXC)));

    // R5
    own_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == F_FILL && bus_gnt && !snp_conflict && cpu_we) |=> (ln_st == LN_MOD));

    // R4
    silent_upgrade_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == F_IDLE && cpu_req && cpu_we && !snp_conflict && hit && ln_st == LN_EXC)
        |=> (cpu_done && !bus_req && ln_st == LN_MOD));

    // R10
    local_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == F_IDLE && cpu_req && !cpu_we && !snp_conflict && hit)
        |=> (cpu_done && !bus_req && cpu_rdata == $past(ln_data)));

    // R11
    snoop_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && snp_conflict) |=> !bus_req);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && !snp_conflict)
        |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_shared,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_e          a_st, b_st, a_wst, b_wst;
    logic [TAG_W-1:0]  a_tag, b_tag, a_wtag;
    logic [DATA_W-1:0] a_data, b_data, a_wdata;
    logic              a_wen;
    snoop_rsp_t        rsp;
    logic              conflict;
    logic [IDX_W-1:0]  cpu_idx, snp_idx;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign snp_idx = snp_addr[IDX_W-1:0];

    mesi_line_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .a_idx  (cpu_idx),
        .a_st   (a_st),
        .a_tag  (a_tag),
        .a_data (a_data),
        .a_wen  (a_wen),
        .a_wst  (a_wst),
        .a_wtag (a_wtag),
        .a_wdata(a_wdata),
        .b_idx  (snp_idx),
        .b_st   (b_st),
        .b_tag  (b_tag),
        .b_data (b_data),
        .b_wen  (rsp.upd),
        .b_wst  (b_wst)
    );

    mesi_snoop_unit #(
        .TAG_W(TAG_W)
    ) u_snoop (
        .snp_valid(snp_valid),
        .snp_cmd  (snp_cmd),
        .snp_tag  (snp_addr[ADDR_W-1:IDX_W]),
        .ln_st    (b_st),
        .ln_tag   (b_tag),
        .rsp      (rsp),
        .upd_st   (b_wst)
    );

    assign conflict   = rsp.hit && (snp_idx == cpu_idx);
    assign snp_shared = rsp.shared;
    assign snp_flush  = rsp.flush;
    assign snp_data   = b_data;

    mesi_cpu_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .cpu_done    (cpu_done),
        .cpu_rdata   (cpu_rdata),
        .ln_st       (a_st),
        .ln_tag      (a_tag),
        .ln_data     (a_data),
        .snp_conflict(conflict),
        .bus_req     (bus_req),
        .bus_cmd     (bus_cmd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_gnt     (bus_gnt),
        .bus_shared  (bus_shared),
        .bus_rdata   (bus_rdata),
        .wr_en       (a_wen),
        .wr_st       (a_wst),
        .wr_tag      (a_wtag),
        .wr_data     (a_wdata)
    );

    // R8
    exc_no_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_cmd == BC_READ && snp_shared && !snp_flush) |-> (b_st != LN_MOD));

    // R3
    holder_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_cmd == BC_READ && snp_flush) |-> snp_shared);

    // R7
    readx_no_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_cmd == BC_READX) |-> !snp_shared);

endmodule

// File: tb/test_mesi_snoop_ctrl.sv
module test_mesi_snoop_ctrl;

    localparam int AW = 8;
    localparam int DW = 16;

    typedef struct {
        bit          rd;
        logic [DW-1:0] data;
        int          traffic;
        string       rq;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          c_req   [2];
    logic          c_we    [2];
    logic [AW-1:0] c_addr  [2];
    logic [DW-1:0] c_wd    [2];
    logic          c_done  [2];
    logic [DW-1:0] c_rd    [2];
    logic          b_req   [2];
    logic [1:0]    b_cmd   [2];
    logic [AW-1:0] b_addr  [2];
    logic [DW-1:0] b_wd    [2];
    logic          b_gnt   [2];
    logic          b_sh    [2];
    logic [DW-1:0] b_rdata [2];
    logic          s_val   [2];
    logic [1:0]    s_cmd   [2];
    logic [AW-1:0] s_addr  [2];
    logic          s_sh    [2];
    logic          s_fl    [2];
    logic [DW-1:0] s_data  [2];

    logic [DW-1:0] mem     [256];
    logic [DW-1:0] ref_mem [256];

    for (genvar g = 0; g < 2; g++) begin : g_cache
        mesi_snoop_ctrl i_mesi_snoop_ctrl (
            .clk(clk), .rst(rst),
            .cpu_req(c_req[g]), .cpu_we(c_we[g]), .cpu_addr(c_addr[g]),
            .cpu_wdata(c_wd[g]), .cpu_done(c_done[g]), .cpu_rdata(c_rd[g]),
            .bus_req(b_req[g]), .bus_cmd(b_cmd[g]), .bus_addr(b_addr[g]),
            .bus_wdata(b_wd[g]), .bus_gnt(b_gnt[g]), .bus_shared(b_sh[g]),
            .bus_rdata(b_rdata[g]),
            .snp_valid(s_val[g]), .snp_cmd(s_cmd[g]), .snp_addr(s_addr[g]),
            .snp_shared(s_sh[g]), .snp_flush(s_fl[g]), .snp_data(s_data[g])
        );
    end

    // Bus model: fixed priority to cache 0, one transaction per cycle
    always_comb begin
        b_gnt[0] = b_req[0];
        b_gnt[1] = b_req[1] && !b_req[0];
        for (int g = 0; g < 2; g++) begin
            s_val[g]   = b_gnt[1-g];
            s_cmd[g]   = b_cmd[1-g];
            s_addr[g]  = b_addr[1-g];
            b_sh[g]    = s_sh[1-g];
            b_rdata[g] = s_fl[1-g] ? s_data[1-g] : mem[b_addr[g]];
        end
    end

    always @(posedge clk) begin
        for (int g = 0; g < 2; g++) begin
            if (b_gnt[g] && b_cmd[g] == 2'd2) mem[b_addr[g]] <= b_wd[g];
            if (s_fl[g]) mem[s_addr[g]] <= s_data[g];
        end
    end

    int checks = 0;
    int fails  = 0;
    int tcnt [2];
    bit prev_done [2];
    item_t q0 [$];
    item_t q1 [$];

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'(16'h0100 + a * 7);
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Monitor: pops scoreboard items on completion pulses
    always @(negedge clk) begin
        if (!rst) begin
            for (int g = 0; g < 2; g++) begin
                if (b_gnt[g]) tcnt[g]++;
                if (c_done[g]) begin
                    item_t it;
                    check(!prev_done[g], "R12", "done pulse length", 1, 0);
                    if (g == 0 && q0.size() > 0) it = q0.pop_front();
                    else if (g == 1 && q1.size() > 0) it = q1.pop_front();
                    else begin it.rd = 0; it.traffic = -1; it.rq = "R12"; it.data = '0; end
                    if (it.rd)
                        check(c_rd[g] === it.data, it.rq, "read data", int'(c_rd[g]), int'(it.data));
                    if (it.traffic >= 0)
                        check(tcnt[g] == it.traffic, it.rq, "bus transactions", tcnt[g], it.traffic);
                    tcnt[g] = 0;
                end
                prev_done[g] = c_done[g];
            end
        end
    end

    task automatic op(input int g, input bit we, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input int tr, input string rq);
        item_t it;
        bit seen;
        it.rd = !we;
        it.data = ref_mem[a];
        it.traffic = tr;
        it.rq = rq;
        @(negedge clk);
        c_req[g] = 1'b1; c_we[g] = we; c_addr[g] = a; c_wd[g] = d;
        if (g == 0) q0.push_back(it); else q1.push_back(it);
        seen = 0;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (c_done[g]) begin seen = 1; break; end
        end
        c_req[g] = 1'b0;
        if (!seen) check(0, rq, "no completion", 0, 1);
    endtask

    task automatic rd(input int g, input logic [AW-1:0] a, input int tr, input string rq);
        op(g, 1'b0, a, '0, tr, rq);
    endtask

    task automatic wr(input int g, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int tr, input string rq);
        op(g, 1'b1, a, d, tr, rq);
        ref_mem[a] = d;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 60000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = init_val(i);
            ref_mem[i] = init_val(i);
        end
        for (int g = 0; g < 2; g++) begin
            c_req[g] = 0; c_we[g] = 0; c_addr[g] = '0; c_wd[g] = '0;
            tcnt[g] = 0; prev_done[g] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        for (int g = 0; g < 2; g++) begin
            check(b_req[g] == 1'b0, "R1", "bus_req after reset", int'(b_req[g]), 0);
            check(c_done[g] == 1'b0, "R1", "cpu_done after reset", int'(c_done[g]), 0);
        end
        // index 0 traffic: addresses 0x10 and 0x20 share a line
        rd(0, 8'h10, 1, "R1");           // cold miss, fills Exclusive (R2)
        wr(0, 8'h10, 16'hAAAA, 0, "R4"); // E -> M silently
        rd(0, 8'h10, 0, "R10");          // hit in M
        rd(1, 8'h10, 1, "R6");           // c0 flushes, c1 gets AAAA as Shared (R3)
        wr(1, 8'h10, 16'hBBBB, 1, "R5"); // upgrade from S is a bus transaction
        rd(0, 8'h10, 1, "R6");           // c0 was invalidated; gets BBBB from c1
        wr(0, 8'h10, 16'hCCCC, 1, "R7"); // c1 S -> I
        wr(1, 8'h10, 16'hDDDD, 1, "R7"); // miss write; c0 M flushes and invalidates
        rd(0, 8'h10, 1, "R7");           // c0 must miss after losing its M copy
        wr(0, 8'h10, 16'h1234, 1, "R5");
        rd(1, 8'h20, 1, "R2");           // c1 E on 0x20
        rd(0, 8'h20, 2, "R9");           // write back M 0x10 then fill; c1 E -> S (R8)
        wr(1, 8'h20, 16'h5678, 1, "R8"); // c1 now S, so an upgrade is needed
        rd(0, 8'h10, 1, "R9");           // memory holds the written-back 1234
        wr(0, 8'h10, 16'h4321, 0, "R4");
        rd(1, 8'h10, 2, "R9");           // c1 writes back 0x20, takes 4321 from c0
        rd(0, 8'h20, 1, "R9");           // c0 drops its S victim silently
        rd(0, 8'h20, 0, "R10");
        // index 1: silent drop of an Exclusive victim
        rd(0, 8'h21, 1, "R2");
        rd(0, 8'h25, 1, "R9");
        rd(0, 8'h21, 1, "R9");
        // index 3: simultaneous requests
        fork
            rd(0, 8'h13, 1, "R2");
            rd(1, 8'h13, 1, "R3");
        join
        fork
            op(0, 1'b1, 8'h13, 16'h1111, 1, "R11");
            op(1, 1'b1, 8'h13, 16'h2222, 1, "R11");
        join
        ref_mem[8'h13] = 16'h2222;       // cache 1 wins the line last
        rd(0, 8'h13, 1, "R11");
        rd(1, 8'h13, 0, "R11");
        rd(1, 8'h13, 0, "R10");
        repeat (4) @(negedge clk);
        check(q0.size() == 0 && q1.size() == 0, "R12", "scoreboard drained",
              q0.size() + q1.size(), 0);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule